// File: doc/BRIEF.md
# Dual-Channel Colour Map Router

This block turns per-pixel items from two video channels (A and B) into one registered 8-bit red, green and blue triple. It holds three lookup tables: a 1024-entry main map of 24-bit colours and two 256-entry maps of 8 bits, one feeding blue and one feeding green. A host writes all three tables through one write port.

Three mode pins set how the items become map addresses. The split pin chooses whether the main-map address takes all eight bits of A with two bits of B, or six bits of A with four bits of B. The bypass pin takes B out of the main-map address and sends it to the blue map instead. The direct-colour pin only works with bypass set. In that mode, successive A items alternate between the main map and the green map, so memory drives three independent colour channels. The mode pins are captured only at a line-start strobe, so the modes cannot change partway through a scan line.

The output is two edges behind the item that produced it. In normal modes there is one triple for every item clock. In direct-colour mode there is one triple for every pair of A items.

Top module: `colormap_router`

## Requirements
- R1: With split mode set (mode_split=1) and bypass off, the main-map address is {a_item[7:0], b_item[7:6]}.
- R2: With split mode clear and bypass off, the main-map address is {a_item[7:2], b_item[7:4]}.
- R3: With bypass on, B does not enter the main-map address. The low address bits are zero: {a_item,2'b00} with split set, {a_item[7:2],4'b0000} with split clear. Blue is the main map's blue byte OR the blue-map entry at b_item.
- R4: With bypass off, red, green and blue equal bits [23:16], [15:8] and [7:0] of the main-map entry. The auxiliary maps contribute nothing.
- R5: In direct-colour mode, the first item after item_vld rises addresses the main map, and the second addresses the green map. Green is the main map's green byte OR the green-map entry. B is taken with the first item of each pair.
- R6: In direct-colour mode, exactly one triple (pix_valid pulse) is produced per pair of items, never on two consecutive cycles.
- R7: In normal modes, each cycle with item_vld high yields a triple on pix_valid two clock edges later. A cycle with item_vld low yields none.
- R8: The mode pins are captured only on a cycle with line_start high, and that cycle already uses the new modes. Mode pin changes at other times have no effect.
- R9: With disp_en low, a host write (host_sel 0 = main map using host_addr[9:0]/host_data[23:0], 1 = blue map, 2 = green map using host_addr[7:0]/host_data[7:0]) lands at that clock edge.
- R10: With disp_en high, a host write is held and lands one clock edge later. A read in progress still sees the old entry.
- R11: After reset, red, green, blue and pix_valid are zero.
- R12: Direct-colour mode is ignored unless bypass is also set. The block then behaves as a normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start-of-line strobe; captures the mode pins |
| mode_split | input | 1 | 1: 8 A bits + 2 B bits; 0: 6 A bits + 4 B bits |
| mode_bypass | input | 1 | Routes B to the blue map instead of the main map |
| mode_direct | input | 1 | Direct-colour mode (needs mode_bypass) |
| item_vld | input | 1 | Channel items valid this cycle |
| a_item | input | 8 | Channel A item |
| b_item | input | 8 | Channel B item |
| disp_en | input | 1 | Display active; host writes are deferred one cycle |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Target map: 0 main, 1 blue, 2 green |
| host_addr | input | 10 | Map entry address |
| host_data | input | 24 | Write data |
| red | output | 8 | Red output register |
| green | output | 8 | Green output register |
| blue | output | 8 | Blue output register |
| pix_valid | output | 1 | A new triple is present |

## Verification
The assertions assume that item_vld is low on every line_start cycle. They also assume that direct-colour streams arrive as whole pairs of consecutive valid items, and that a held write and a direct write never target the same entry in one cycle. The bench drops item_vld around every mode change and drives direct-colour items strictly in pairs. It writes every map entry with display disabled before any reads, and it times its deferred-write probes so that only one write is ever in flight.

// File: rtl/colormap_router.sv
module colormap_router #(
  parameter int IW = 8,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_start,
  input  logic            mode_split,
  input  logic            mode_bypass,
  input  logic            mode_direct,
  input  logic            item_vld,
  input  logic [IW-1:0]   a_item,
  input  logic [IW-1:0]   b_item,
  input  logic            disp_en,
  input  logic            host_we,
  input  logic [1:0]      host_sel,
  input  logic [IW+1:0]   host_addr,
  input  logic [3*CW-1:0] host_data,
  output logic [CW-1:0]   red,
  output logic [CW-1:0]   green,
  output logic [CW-1:0]   blue,
  output logic            pix_valid
);
  localparam int MAW = IW + 2;
  localparam int MD  = 1 << MAW;
  localparam int XD  = 1 << IW;
  localparam int MW  = 3 * CW;

  logic [MW-1:0] mmap [MD];
  logic [CW-1:0] bmap [XD];
  logic [CW-1:0] gmap [XD];

  logic split_q, byp_q, dir_q, ph_q, s1_v, byp_s1, dir_s1;
  logic [MAW-1:0] maddr_q;
  logic [IW-1:0]  baddr_q, gaddr_q;
  logic           pend_v;
  logic [1:0]     pend_sel;
  logic [MAW-1:0] pend_addr;
  logic [MW-1:0]  pend_data;

  wire split_e = line_start ? mode_split : split_q;
  wire byp_e   = line_start ? mode_bypass : byp_q;
  wire dir_e   = line_start ? (mode_direct & mode_bypass) : dir_q;
  wire a_main  = !dir_e || !ph_q;

  logic [MAW-1:0] maddr_d;
  always_comb begin
    if (byp_e)
      maddr_d = split_e ? {a_item, 2'b00} : {a_item[IW-1 -: IW-2], 4'b0000};
    else
      maddr_d = split_e ? {a_item, b_item[IW-1 -: 2]} : {a_item[IW-1 -: IW-2], b_item[IW-1 -: 4]};
  end

  wire [MW-1:0] mword = mmap[maddr_q];
  wire [CW-1:0] bx    = byp_s1 ? bmap[baddr_q] : '0;
  wire [CW-1:0] gx    = dir_s1 ? gmap[gaddr_q] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_q <= 1'b0; byp_q <= 1'b0; dir_q <= 1'b0; ph_q <= 1'b0;
      s1_v <= 1'b0; byp_s1 <= 1'b0; dir_s1 <= 1'b0; pix_valid <= 1'b0;
      maddr_q <= '0; baddr_q <= '0; gaddr_q <= '0;
      red <= '0; green <= '0; blue <= '0;
      pend_v <= 1'b0; pend_sel <= '0; pend_addr <= '0; pend_data <= '0;
    end else begin
      if (line_start) begin
        split_q <= mode_split; byp_q <= mode_bypass; dir_q <= mode_direct & mode_bypass;
      end
      ph_q <= item_vld && dir_e && !ph_q;
      if (item_vld && a_main) begin
        maddr_q <= maddr_d;
        baddr_q <= b_item;
      end
      if (item_vld && !a_main) gaddr_q <= a_item;
      s1_v   <= item_vld && (!dir_e || ph_q);
      byp_s1 <= byp_e;
      dir_s1 <= dir_e;
      pix_valid <= s1_v;
      if (s1_v) begin
        red   <= mword[MW-1 -: CW];
        green <= mword[CW +: CW] | gx;
        blue  <= mword[0 +: CW] | bx;
      end
      pend_v    <= host_we && disp_en;
      pend_sel  <= host_sel;
      pend_addr <= host_addr;
      pend_data <= host_data;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_v) begin
      case (pend_sel)
        2'd0: mmap[pend_addr] <= pend_data;
        2'd1: bmap[pend_addr[IW-1:0]] <= pend_data[CW-1:0];
        2'd2: gmap[pend_addr[IW-1:0]] <= pend_data[CW-1:0];
        default: ;
      endcase
    end
    if (host_we && !disp_en) begin
      case (host_sel)
        2'd0: mmap[host_addr] <= host_data;
        2'd1: bmap[host_addr[IW-1:0]] <= host_data[CW-1:0];
        2'd2: gmap[host_addr[IW-1:0]] <= host_data[CW-1:0];
        default: ;
      endcase
    end
  end

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !item_vld |-> ##2 !pix_valid);

  p_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (item_vld && dir_e && !ph_q) |-> ##2 !pix_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable({split_q, byp_q, dir_q}));

  p_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (item_vld && a_main && split_e && !byp_e) |=> maddr_q[MAW-1:2] == $past(a_item));

  p_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && pend_sel == 2'd0 && !(host_we && !disp_en)) |=>
      mmap[$past(pend_addr)] == $past(pend_data));
endmodule

// File: tb/sim_colormap_router.sv
module sim_colormap_router;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, line_start = 1'b0, mode_split = 1'b0, mode_bypass = 1'b0, mode_direct = 1'b0;
  logic item_vld = 1'b0, disp_en = 1'b0, host_we = 1'b0;
  logic [7:0] a_item = '0, b_item = '0;
  logic [1:0] host_sel = '0;
  logic [9:0] host_addr = '0;
  logic [23:0] host_data = '0;
  logic [7:0] red, green, blue;
  logic pix_valid;

  colormap_router u0 (.clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_split(mode_split),
    .mode_bypass(mode_bypass), .mode_direct(mode_direct), .item_vld(item_vld), .a_item(a_item),
    .b_item(b_item), .disp_en(disp_en), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_data(host_data), .red(red), .green(green), .blue(blue),
    .pix_valid(pix_valid));

  int checks = 0, errors = 0, pv_cnt = 0;
  bit sb_on = 1'b0, done = 1'b0;
  logic [23:0] mm [1024];
  logic [7:0] bm [256], gm [256];
  bit md_split = 0, md_byp = 0, md_dir = 0;
  logic [23:0] exp_q [$];
  string tag_q [$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pix_valid) pv_cnt++;
    if (rst_n && sb_on && pix_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual unexpected triple %h expected none", {red, green, blue});
      end else begin
        chk(tag_q.pop_front(), {8'h0, red, green, blue}, {8'h0, exp_q.pop_front()});
      end
    end
  end

  function automatic logic [23:0] exp_norm(logic [7:0] a, logic [7:0] b);
    logic [9:0] ad;
    logic [23:0] m;
    if (md_byp) ad = md_split ? {a, 2'b00} : {a[7:2], 4'b0000};
    else        ad = md_split ? {a, b[7:6]} : {a[7:2], b[7:4]};
    m = mm[ad];
    return {m[23:16], m[15:8], m[7:0] | (md_byp ? bm[b] : 8'h00)};
  endfunction

  task automatic host_write(logic [1:0] s, logic [9:0] ad, logic [23:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_addr = ad; host_data = d;
  endtask

  task automatic set_mode(bit sp, bit by, bit di);
    @(negedge clk);
    item_vld = 1'b0; line_start = 1'b1;
    mode_split = sp; mode_bypass = by; mode_direct = di;
    md_split = sp; md_byp = by; md_dir = di & by;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic drive_one(string tag, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    item_vld = 1'b1; a_item = a; b_item = b;
    exp_q.push_back(exp_norm(a, b)); tag_q.push_back(tag);
  endtask

  task automatic drive_pair(string tag, logic [7:0] a1, logic [7:0] a2, logic [7:0] b);
    logic [23:0] e;
    e = exp_norm(a1, b);
    e[15:8] = e[15:8] | gm[a2];
    @(negedge clk);
    item_vld = 1'b1; a_item = a1; b_item = b;
    @(negedge clk);
    a_item = a2; b_item = ~b;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic drain(string tag);
    @(negedge clk); item_vld = 1'b0;
    repeat (4) @(negedge clk);
    chk(tag, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pv0;
    for (int i = 0; i < 1024; i++) mm[i] = {8'(i * 7 + 1), 8'((i >> 1) ^ 8'h33), 8'(i + (i >> 8) * 17)};
    for (int i = 0; i < 256; i++) begin bm[i] = 8'(i * 5 + 2); gm[i] = 8'(i ^ 8'hc3); end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {7'h0, pix_valid, red, green, blue}, 0);

    for (int i = 0; i < 1024; i++) host_write(2'd0, 10'(i), mm[i]);
    for (int i = 0; i < 256; i++) host_write(2'd1, 10'(i), {16'h0, bm[i]});
    for (int i = 0; i < 256; i++) host_write(2'd2, 10'(i), {16'h0, gm[i]});
    @(negedge clk); host_we = 1'b0;
    chk("R11", {7'h0, pix_valid, red, green, blue}, 0);
    sb_on = 1'b1;

    set_mode(1, 0, 0);
    for (int i = 0; i < 8; i++) drive_one("R1", 8'(i * 37 + 5), 8'(i * 91 + 3));
    drive_one("R4", 8'hff, 8'hc0);
    drain("R7");

    set_mode(0, 0, 0);
    for (int i = 0; i < 8; i++) drive_one("R2", 8'(i * 53 + 11), 8'(i * 29 + 200));
    drain("R2");

    set_mode(1, 1, 0);
    for (int i = 0; i < 6; i++) drive_one("R3", 8'(i * 17 + 2), 8'(i * 61 + 9));
    set_mode(0, 1, 0);
    for (int i = 0; i < 6; i++) drive_one("R3", 8'(i * 43 + 7), 8'(i * 13 + 100));
    drain("R3");

    set_mode(1, 1, 1);
    pv0 = pv_cnt;
    for (int i = 0; i < 4; i++) drive_pair("R5", 8'(i * 71 + 1), 8'(i * 23 + 4), 8'(i * 47 + 8));
    drain("R5");
    chk("R6", pv_cnt - pv0, 4);
    set_mode(0, 1, 1);
    for (int i = 0; i < 3; i++) drive_pair("R5", 8'(i * 31 + 66), 8'(i * 19 + 130), 8'(i * 83));
    drain("R6");

    set_mode(1, 0, 1);
    pv0 = pv_cnt;
    for (int i = 0; i < 4; i++) drive_one("R12", 8'(i * 59 + 3), 8'(i * 7 + 250));
    drain("R12");
    chk("R12", pv_cnt - pv0, 4);

    set_mode(1, 0, 0);
    @(negedge clk);
    mode_split = 1'b0; mode_bypass = 1'b1; mode_direct = 1'b1;
    for (int i = 0; i < 6; i++) drive_one("R8", 8'(i * 41 + 9), 8'(i * 67 + 5));
    drain("R8");

    sb_on = 1'b0;
    set_mode(1, 0, 0);
    @(negedge clk); item_vld = 1'b1; a_item = 8'd5; b_item = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10", {8'h0, red, green, blue}, {8'h0, mm[20]});
    disp_en = 1'b1; host_we = 1'b1; host_sel = 2'd0; host_addr = 10'd20; host_data = 24'h123456;
    @(negedge clk); host_we = 1'b0;
    chk("R10", {8'h0, red, green, blue}, {8'h0, mm[20]});
    @(negedge clk);
    chk("R10", {8'h0, red, green, blue}, {8'h0, mm[20]});
    @(negedge clk);
    chk("R10", {8'h0, red, green, blue}, 32'h00123456);
    disp_en = 1'b0; host_we = 1'b1; host_data = 24'hab9c3e;
    @(negedge clk); host_we = 1'b0;
    chk("R9", {8'h0, red, green, blue}, 32'h00123456);
    @(negedge clk);
    chk("R9", {8'h0, red, green, blue}, 32'h00ab9c3e);
    mm[20] = 24'hab9c3e;
    @(negedge clk); item_vld = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7", {31'h0, pix_valid}, 0);

    sb_on = 1'b1;
    for (int i = 0; i < 3; i++) drive_one("R9", 8'd5, 8'(i * 40));
    drain("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule